// File: doc/BRIEF.md
# Snooping MESI Cache-Line Controller

This block keeps a small private cache coherent with its peers on a shared snooping bus, using a write-invalidate protocol with four line states: Modified, Exclusive, Shared and Invalid. It holds a directly indexed array of lines, each with a tag, a state and one data word. Coherence is tracked for the whole line. Lines are write-back.

On the processor side the block accepts reads and writes. Hits complete in the cycle they are presented. Misses, upgrades and dirty evictions become bus transactions that wait for a grant. On the snoop side it watches read-miss, write-miss and invalidate transactions from other caches. It supplies data when it holds the only current copy, and it reports whether it holds the snooped line at all.

A line held Exclusive is written without using the bus. A snooped read miss to an Exclusive or Modified line is answered by this cache. When two caches try to upgrade the same line, the cache that loses drops its copy, fetches the line again and then retries its write.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. `cpu_ready_o`, `bus_req_o` and `snoop_supply_o` are low, and the first read of any address needs a bus transaction.
- R2: A read miss issues `bus_cmd_o`=1 (read miss) for the request address. On grant the line is filled from `bus_rdata_i` and its data is returned. The line is installed Exclusive when `bus_shared_i` is 0 at the grant and Shared when it is 1.
- R3: A read hit raises `cpu_ready_o` in the same cycle with the line's data on `cpu_rdata_o`, and issues no bus request.
- R4: A write to a line in Exclusive or Modified state completes in the same cycle with no bus request, and the line becomes Modified.
- R5: A write to a Shared line raises `bus_req_o` with `bus_cmd_o`=3 (invalidate) and holds `cpu_ready_o` low until the grant. After the grant the line is Modified and the write completes on the following cycle.
- R6: A write miss issues `bus_cmd_o`=2 (write miss). It installs the fetched line as Modified and then applies the write.
- R7: A snooped write miss (`snoop_cmd_i`=2) or invalidate (`snoop_cmd_i`=3) to a line held valid makes that line Invalid.
- R8: A snooped read miss (`snoop_cmd_i`=1) to a line held Exclusive or Modified raises `snoop_supply_o` in the same cycle, drives the line's data on `snoop_data_o`, and leaves the line Shared. To a Shared line it supplies nothing. `snoop_shared_o` is high in the same cycle whenever the snooped line is held valid.
- R9: A snooped write miss to a Modified line supplies that line's data before the line becomes Invalid.
- R10: If a pending upgrade loses its line to a snooped invalidate or write miss, the upgrade is dropped. The controller then issues a write miss for the same address and completes the write.
- R11: A miss whose victim is Modified first issues `bus_cmd_o`=4 (write-back) carrying the victim's address and data, then the fill. A clean victim is replaced without a write-back.
- R12: In a cycle with `snoop_valid_i` high, `cpu_ready_o` is low and `bus_gnt_i` is ignored. The processor request is served once the snoop is gone.

Address layout: the low log2(NUM_LINES) bits of an address are the line index and the rest is the tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, held until ready |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Request address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_ready_o | output | 1 | Request completes this cycle |
| cpu_rdata_o | output | DATA_W | Read data |
| bus_req_o | output | 1 | Bus transaction pending |
| bus_cmd_o | output | 3 | 1 read miss, 2 write miss, 3 invalidate, 4 write-back |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_wdata_o | output | DATA_W | Write-back data |
| bus_gnt_i | input | 1 | Grant; the transaction takes effect this cycle |
| bus_rdata_i | input | DATA_W | Fill data, valid with grant |
| bus_shared_i | input | 1 | Another cache holds the filled line |
| snoop_valid_i | input | 1 | Snooped transaction present |
| snoop_cmd_i | input | 2 | 1 read miss, 2 write miss, 3 invalidate |
| snoop_addr_i | input | ADDR_W | Snooped address |
| snoop_supply_o | output | 1 | This cache answers with data |
| snoop_data_o | output | DATA_W | Supplied data |
| snoop_shared_o | output | 1 | Snooped line is held valid here |

## Verification
A table of processor operations runs the cache through cold misses, hits and writes to Exclusive lines. It then forces evictions with both dirty and clean victims, so that the recorded sequence of bus commands separates silent transitions from upgrades, write-backs and fills. Data written before a dirty eviction and read back after a refill shows that the write-back carried the right value. Directed snoops against Exclusive, Shared and Modified lines are followed by local writes or snooped reads, which reveal the resulting state through the bus command issued or through the shared flag. A snooped invalidate that arrives while an upgrade is waiting, together with a grant in the same cycle, separates a correct abort and refetch from a lost race.

// File: rtl/mesi_pkg.sv
`timescale 1ns/1ps
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} line_state_e;
  typedef enum logic [2:0] {BUS_NONE = 3'd0, BUS_RD = 3'd1, BUS_WR = 3'd2,
                            BUS_INV = 3'd3, BUS_WB = 3'd4} bus_cmd_e;
  typedef enum logic [1:0] {SNP_NONE = 2'd0, SNP_RD = 2'd1, SNP_WR = 2'd2,
                            SNP_INV = 2'd3} snoop_cmd_e;
  typedef enum logic [1:0] {CF_IDLE, CF_WB, CF_UPG, CF_FILL} ctl_state_e;
endpackage

// File: rtl/mesi_line_array.sv
`timescale 1ns/1ps
module mesi_line_array
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 4,
  parameter int DATA_W    = 16,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [IDX_W-1:0]             a_idx_i,
  output line_state_e                  a_state_o,
  output logic [TAG_W-1:0]             a_tag_o,
  output logic [DATA_W-1:0]            a_data_o,
  input  logic [IDX_W-1:0]             b_idx_i,
  output line_state_e                  b_state_o,
  output logic [TAG_W-1:0]             b_tag_o,
  output logic [DATA_W-1:0]            b_data_o,
  input  logic                         wr_en_i,
  input  logic [IDX_W-1:0]             wr_idx_i,
  input  line_state_e                  wr_state_i,
  input  logic [TAG_W-1:0]             wr_tag_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  output line_state_e [NUM_LINES-1:0]  state_vec_o
);
  line_state_e       st_q  [NUM_LINES];
  logic [TAG_W-1:0]  tag_q [NUM_LINES];
  logic [DATA_W-1:0] dat_q [NUM_LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (wr_idx_i == IDX_W'(i)) begin
          st_q[i]  <= wr_state_i;
          tag_q[i] <= wr_tag_i;
          dat_q[i] <= wr_data_i;
        end
      end
    end
  end

  assign a_state_o = st_q[a_idx_i];
  assign a_tag_o   = tag_q[a_idx_i];
  assign a_data_o  = dat_q[a_idx_i];
  assign b_state_o = st_q[b_idx_i];
  assign b_tag_o   = tag_q[b_idx_i];
  assign b_data_o  = dat_q[b_idx_i];

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_vec
    assign state_vec_o[g] = st_q[g];
  end
endmodule

// File: rtl/mesi_snoop_unit.sv
`timescale 1ns/1ps
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             valid_i,
  input  snoop_cmd_e       cmd_i,
  input  logic [TAG_W-1:0] snp_tag_i,
  input  line_state_e      line_state_i,
  input  logic [TAG_W-1:0] line_tag_i,
  output logic             hit_o,
  output line_state_e      next_state_o,
  output logic             supply_o
);
  always_comb begin
    hit_o        = valid_i && (cmd_i != SNP_NONE) && (line_state_i != ST_I)
                   && (line_tag_i == snp_tag_i);
    next_state_o = line_state_i;
    supply_o     = 1'b0;
    if (hit_o) begin
      unique case (cmd_i)
        SNP_RD: begin
          next_state_o = ST_S;
          supply_o     = (line_state_i == ST_E) || (line_state_i == ST_M);
        end
        SNP_WR: begin
          next_state_o = ST_I;
          supply_o     = (line_state_i == ST_M);  // memory is stale
        end
        default: next_state_o = ST_I;
      endcase
    end
  end
endmodule

// File: rtl/mesi_cpu_ctrl.sv
`timescale 1ns/1ps
module mesi_cpu_ctrl
  import mesi_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  localparam int ADDR_W = TAG_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  line_state_e       line_state_i,
  input  logic [TAG_W-1:0]  line_tag_i,
  input  logic [DATA_W-1:0] line_data_i,
  input  logic              snoop_busy_i,
  input  logic              gnt_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              shared_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bus_req_o,
  output bus_cmd_e          bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              upd_en_o,
  output line_state_e       upd_state_o,
  output logic [TAG_W-1:0]  upd_tag_o,
  output logic [DATA_W-1:0] upd_data_o
);
  ctl_state_e cs_q, cs_d;
  logic       hit, take;

  assign hit     = (line_state_i != ST_I) && (line_tag_i == tag_i);
  assign take    = gnt_i && !snoop_busy_i;
  assign rdata_o = line_data_i;

  always_comb begin
    cs_d        = cs_q;
    ready_o     = 1'b0;
    bus_req_o   = 1'b0;
    bus_cmd_o   = BUS_NONE;
    bus_addr_o  = {tag_i, idx_i};
    bus_wdata_o = line_data_i;
    upd_en_o    = 1'b0;
    upd_state_o = line_state_i;
    upd_tag_o   = line_tag_i;
    upd_data_o  = line_data_i;
    unique case (cs_q)
      CF_IDLE: if (req_i && !snoop_busy_i) begin
        if (hit && !we_i) begin
          ready_o = 1'b1;
        end else if (hit && (line_state_i != ST_S)) begin
          ready_o     = 1'b1;
          upd_en_o    = 1'b1;
          upd_state_o = ST_M;
          upd_data_o  = wdata_i;
        end else if (hit) begin
          cs_d = CF_UPG;
        end else if (line_state_i == ST_M) begin
          cs_d = CF_WB;
        end else begin
          cs_d = CF_FILL;  // clean victim is overwritten silently
        end
      end
      CF_WB: begin
        if (line_state_i != ST_M) begin
          cs_d = CF_IDLE;  // victim lost its dirty data to a snoop
        end else begin
          bus_req_o  = 1'b1;
          bus_cmd_o  = BUS_WB;
          bus_addr_o = {line_tag_i, idx_i};
          if (take) begin
            upd_en_o    = 1'b1;
            upd_state_o = ST_I;
            cs_d        = CF_IDLE;
          end
        end
      end
      CF_UPG: begin
        if (!(hit && line_state_i == ST_S)) begin
          cs_d = CF_IDLE;  // lost the race: retry from idle as a miss
        end else begin
          bus_req_o = 1'b1;
          bus_cmd_o = BUS_INV;
          if (take) begin
            upd_en_o    = 1'b1;
            upd_state_o = ST_M;
            cs_d        = CF_IDLE;
          end
        end
      end
      default: begin
        bus_req_o = 1'b1;
        bus_cmd_o = we_i ? BUS_WR : BUS_RD;
        if (take) begin
          upd_en_o    = 1'b1;
          upd_tag_o   = tag_i;
          upd_data_o  = fill_data_i;
          upd_state_o = we_i ? ST_M : (shared_i ? ST_S : ST_E);
          cs_d        = CF_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_q <= CF_IDLE;
    else         cs_q <= cs_d;
  end

  // R11: a write-back is only ever issued for a dirty line
  a_r11_wb_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_cmd_o == BUS_WB) |-> (line_state_i == ST_M));
endmodule

// File: rtl/mesi_line_ctrl.sv
`timescale 1ns/1ps
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int TAG_W     = 4,
  parameter int DATA_W    = 16,
  localparam int IDX_W    = $clog2(NUM_LINES),
  localparam int ADDR_W   = TAG_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  output logic [2:0]        bus_cmd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_gnt_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_shared_i,
  input  logic              snoop_valid_i,
  input  logic [1:0]        snoop_cmd_i,
  input  logic [ADDR_W-1:0] snoop_addr_i,
  output logic              snoop_supply_o,
  output logic [DATA_W-1:0] snoop_data_o,
  output logic              snoop_shared_o
);
  logic [IDX_W-1:0]  cpu_idx, snp_idx;
  logic [TAG_W-1:0]  cpu_tag, snp_tag;
  line_state_e       a_state, b_state, snp_next, upd_state, wr_state;
  logic [TAG_W-1:0]  a_tag, b_tag, upd_tag, wr_tag;
  logic [DATA_W-1:0] a_data, b_data, upd_data, wr_data;
  logic              snp_hit, upd_en, wr_en;
  logic [IDX_W-1:0]  wr_idx;
  bus_cmd_e          bus_cmd;
  snoop_cmd_e        snp_cmd;
  line_state_e [NUM_LINES-1:0] state_vec;

  assign cpu_idx   = cpu_addr_i[IDX_W-1:0];
  assign cpu_tag   = cpu_addr_i[ADDR_W-1:IDX_W];
  assign snp_idx   = snoop_addr_i[IDX_W-1:0];
  assign snp_tag   = snoop_addr_i[ADDR_W-1:IDX_W];
  assign snp_cmd   = snoop_cmd_e'(snoop_cmd_i);
  assign bus_cmd_o = bus_cmd;

  mesi_line_array #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_array (
    .clk_i, .rst_ni,
    .a_idx_i(cpu_idx), .a_state_o(a_state), .a_tag_o(a_tag), .a_data_o(a_data),
    .b_idx_i(snp_idx), .b_state_o(b_state), .b_tag_o(b_tag), .b_data_o(b_data),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_state_i(wr_state),
    .wr_tag_i(wr_tag), .wr_data_i(wr_data), .state_vec_o(state_vec)
  );

  mesi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
    .valid_i(snoop_valid_i), .cmd_i(snp_cmd), .snp_tag_i(snp_tag),
    .line_state_i(b_state), .line_tag_i(b_tag),
    .hit_o(snp_hit), .next_state_o(snp_next), .supply_o(snoop_supply_o)
  );

  mesi_cpu_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_cpu (
    .clk_i, .rst_ni,
    .req_i(cpu_req_i), .we_i(cpu_we_i), .idx_i(cpu_idx), .tag_i(cpu_tag),
    .wdata_i(cpu_wdata_i), .line_state_i(a_state), .line_tag_i(a_tag),
    .line_data_i(a_data), .snoop_busy_i(snoop_valid_i), .gnt_i(bus_gnt_i),
    .fill_data_i(bus_rdata_i), .shared_i(bus_shared_i),
    .ready_o(cpu_ready_o), .rdata_o(cpu_rdata_o),
    .bus_req_o(bus_req_o), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .upd_en_o(upd_en), .upd_state_o(upd_state),
    .upd_tag_o(upd_tag), .upd_data_o(upd_data)
  );

  // single write port: snoop wins, local side is stalled in snoop cycles
  assign wr_en    = snp_hit | upd_en;
  assign wr_idx   = snp_hit ? snp_idx  : cpu_idx;
  assign wr_state = snp_hit ? snp_next : upd_state;
  assign wr_tag   = snp_hit ? b_tag    : upd_tag;
  assign wr_data  = snp_hit ? b_data   : upd_data;

  assign snoop_data_o   = b_data;
  assign snoop_shared_o = snp_hit;

  a_r12_snoop_stalls_cpu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_valid_i |-> !cpu_ready_o);
  a_r5_no_ready_while_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> !cpu_ready_o);
  a_r8_supply_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_supply_o |-> (snoop_valid_i && snoop_shared_o && snp_cmd != SNP_INV));
  a_r7_snoop_kills: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_shared_o && snp_cmd != SNP_RD) |=> (state_vec[$past(snp_idx)] == ST_I));
  a_r8_snoop_read_shares: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snoop_shared_o && snp_cmd == SNP_RD) |=> (state_vec[$past(snp_idx)] == ST_S));
  a_r4_write_makes_m: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_ready_o && cpu_we_i) |=> (state_vec[$past(cpu_idx)] == ST_M));
  a_r5_upgrade_makes_m: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_gnt_i && !snoop_valid_i && bus_cmd == BUS_INV)
    |=> (state_vec[$past(cpu_idx)] == ST_M));
endmodule

// File: tb/mesi_line_ctrl_test.sv
`timescale 1ns/1ps
module mesi_line_ctrl_test;
  localparam int DW = 16;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic          cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req;
  logic [2:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_gnt = 1'b0;
  logic [DW-1:0] bus_rdata = '0;
  logic          bus_shared = 1'b0;
  logic          snp_valid = 1'b0;
  logic [1:0]    snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic          snp_supply;
  logic [DW-1:0] snp_data;
  logic          snp_shared;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [DW-1:0] mem [64];

  mesi_line_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .cpu_wdata_i(cpu_wdata), .cpu_ready_o(cpu_ready), .cpu_rdata_o(cpu_rdata),
    .bus_req_o(bus_req), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_gnt_i(bus_gnt), .bus_rdata_i(bus_rdata),
    .bus_shared_i(bus_shared), .snoop_valid_i(snp_valid), .snoop_cmd_i(snp_cmd),
    .snoop_addr_i(snp_addr), .snoop_supply_o(snp_supply),
    .snoop_data_o(snp_data), .snoop_shared_o(snp_shared)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // seq packs bus commands oldest first, 3 bits each: 1 rd, 2 wr, 3 inv, 4 wb
  typedef struct packed {
    logic [3:0]    rq;
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          shared;
    logic [11:0]   exp_seq;
    logic [DW-1:0] exp_rd;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  1'b0, 6'h04, 16'h0000, 1'b0, 12'h001, 16'hA004}, // R1 R2 cold miss -> E
    '{4'd3,  1'b0, 6'h04, 16'h0000, 1'b0, 12'h000, 16'hA004}, // R3 hit
    '{4'd4,  1'b1, 6'h04, 16'h1110, 1'b0, 12'h000, 16'h0000}, // R4 E silent
    '{4'd4,  1'b1, 6'h04, 16'h1111, 1'b0, 12'h000, 16'h0000}, // R4 M silent
    '{4'd3,  1'b0, 6'h04, 16'h0000, 1'b0, 12'h000, 16'h1111}, // R3
    '{4'd11, 1'b0, 6'h08, 16'h0000, 1'b1, 12'h021, 16'hA008}, // R11 dirty victim
    '{4'd11, 1'b0, 6'h04, 16'h0000, 1'b0, 12'h001, 16'h1111}, // R11 clean victim
    '{4'd6,  1'b1, 6'h05, 16'h2222, 1'b0, 12'h002, 16'h0000}, // R6 write miss
    '{4'd6,  1'b0, 6'h05, 16'h0000, 1'b0, 12'h000, 16'h2222}, // R6
    '{4'd2,  1'b0, 6'h09, 16'h0000, 1'b1, 12'h021, 16'hA009}, // R2 shared fill
    '{4'd5,  1'b1, 6'h09, 16'h3333, 1'b0, 12'h003, 16'h0000}, // R5 upgrade
    '{4'd5,  1'b0, 6'h09, 16'h0000, 1'b0, 12'h000, 16'h3333}, // R5
    '{4'd11, 1'b0, 6'h05, 16'h0000, 1'b0, 12'h021, 16'h2222}  // R11
  };

  task automatic check(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic serve(input logic shared, output logic [11:0] seq,
                       output logic [DW-1:0] rd);
    seq = '0;
    rd  = '0;
    for (int n = 0; n < 60; n++) begin
      #1;
      if (cpu_ready) begin
        if (bus_req) check(1'b0, "R5 ready with bus request", 1, 0);
        rd = cpu_rdata;
        @(posedge clk);
        #1 cpu_req = 1'b0;
        return;
      end
      if (bus_req) begin
        seq = {seq[8:0], bus_cmd};
        if (bus_cmd == 3'd4) mem[bus_addr] = bus_wdata;
        else bus_rdata = mem[bus_addr];
        bus_shared = shared;
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  task automatic start(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
  endtask

  task automatic op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic sh, output logic [11:0] seq, output logic [DW-1:0] rd);
    start(we, a, d);
    serve(sh, seq, rd);
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a,
                       output logic sup, output logic sh, output logic [DW-1:0] d);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    #1;
    sup = snp_supply; sh = snp_shared; d = snp_data;
    if (sup) mem[a] = d;
    @(posedge clk);
    #1 snp_valid = 1'b0;
  endtask

  initial begin
    logic [11:0]   seq;
    logic [DW-1:0] rd;
    logic          sup, sh;
    logic [DW-1:0] sd;
    for (int a = 0; a < 64; a++) mem[a] = 16'hA000 + 16'(a);

    // R1: reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!cpu_ready && !bus_req && !snp_supply, "R1 outputs idle after reset",
          {cpu_ready, bus_req, snp_supply}, 0);

    for (int i = 0; i < NV; i++) begin
      op(VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].shared, seq, rd);
      check(seq == VECS[i].exp_seq, $sformatf("R%0d row %0d bus sequence", VECS[i].rq, i),
            32'(seq), 32'(VECS[i].exp_seq));
      if (!VECS[i].we)
        check(rd == VECS[i].exp_rd, $sformatf("R%0d row %0d read data", VECS[i].rq, i),
              32'(rd), 32'(VECS[i].exp_rd));
    end

    // R8: line 0x04 is E with 1111
    snoop(2'd1, 6'h04, sup, sh, sd);
    check(sup && sh && sd == 16'h1111, "R8 snoop read on E supplies", {sup, sh, sd}, {2'b11, 16'h1111});
    snoop(2'd1, 6'h04, sup, sh, sd);
    check(!sup && sh, "R8 snoop read on S no supply", {sup, sh}, 2'b01);
    op(1'b1, 6'h04, 16'h4444, 1'b0, seq, rd);
    check(seq == 12'h003, "R8 line left Shared needs invalidate", 32'(seq), 32'h003);

    // R9 and R7: write miss snoop on M line
    snoop(2'd2, 6'h04, sup, sh, sd);
    check(sup && sd == 16'h4444, "R9 snoop write miss on M supplies", {sup, sd}, {1'b1, 16'h4444});
    snoop(2'd1, 6'h04, sup, sh, sd);
    check(!sh && !sup, "R7 line invalid after snoop write miss", {sup, sh}, 0);
    op(1'b0, 6'h04, 16'h0, 1'b1, seq, rd);
    check(seq == 12'h001 && rd == 16'h4444, "R7 refetch after invalidation",
          {seq, rd}, {12'h001, 16'h4444});

    // R7: invalidate snoop on E line 0x05
    snoop(2'd3, 6'h05, sup, sh, sd);
    check(sh && !sup, "R7 invalidate hit without supply", {sup, sh}, 2'b01);
    snoop(2'd1, 6'h05, sup, sh, sd);
    check(!sh, "R7 line invalid after invalidate", 32'(sh), 0);

    // R10 and R12: lost upgrade race on Shared line 0x04
    start(1'b1, 6'h04, 16'h5555);
    #1 check(!bus_req && !cpu_ready, "R5 idle decode cycle", {bus_req, cpu_ready}, 0);
    @(negedge clk); #1;
    check(bus_req && bus_cmd == 3'd3 && !cpu_ready, "R5 upgrade requests invalidate",
          {bus_req, bus_cmd, cpu_ready}, {1'b1, 3'd3, 1'b0});
    @(negedge clk); #1;
    check(bus_req && !cpu_ready, "R5 ready held low without grant", {bus_req, cpu_ready}, 2'b10);
    snp_valid = 1'b1; snp_cmd = 2'd3; snp_addr = 6'h04; bus_gnt = 1'b1;
    #1 check(!cpu_ready, "R12 ready low during snoop", 32'(cpu_ready), 0);
    @(negedge clk);
    snp_valid = 1'b0; bus_gnt = 1'b0;
    serve(1'b0, seq, rd);
    check(seq == 12'h002, "R10 loser refetches with write miss", 32'(seq), 32'h002);
    op(1'b0, 6'h04, 16'h0, 1'b0, seq, rd);
    check(seq == 12'h000 && rd == 16'h5555, "R10 retried write landed", {seq, rd}, {12'h0, 16'h5555});

    // R12: snoop to another line stalls a read hit for one cycle
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 6'h04;
    snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 6'h06;
    #1 check(!cpu_ready && !snp_shared, "R12 hit stalled by snoop", {cpu_ready, snp_shared}, 0);
    @(negedge clk);
    snp_valid = 1'b0;
    #1 check(cpu_ready && cpu_rdata == 16'h5555, "R12 hit served after snoop",
             {cpu_ready, cpu_rdata}, {1'b1, 16'h5555});
    @(posedge clk);
    #1 cpu_req = 1'b0;

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule